// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns the addressing part of a decoded instruction into the value that the execute stage needs. It takes a 4-bit mode code, a register selector and a short address field. From these it returns one of three things: an effective memory address, an operand, or nothing. It reads one register through a combinational read port. It also takes the program counter value that has already been advanced past the current instruction. For memory-indirect mode it makes one extra read through a synchronous memory port, which returns data one cycle after the request.

Requests and results both use valid/ready. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low while a request is in progress and while a result waits to be taken. The result is taken on an edge where `res_valid` and `res_ready` are both high. Until then every result output holds its value. For the two auto-update modes the result also carries a register write-back (enable, selector, new value), which the consumer applies when it takes the result.

Top module: `ea_gen_unit`

## Requirements
- R1: After reset, `req_ready` is 1 and both `res_valid` and `mem_rd_en` are 0.
- R2: A request is accepted only on an edge with `req_valid` and `req_ready` both high. `req_ready` is 0 from acceptance until the result has been taken. While `res_valid` is high and `res_ready` is low, every result output stays unchanged.
- R3: For every mode except memory-indirect, `res_valid` rises in the cycle right after acceptance.
- R4: Mode 0000 (implied) and the unused codes 1011 to 1111 return kind none with value 0 and no write-back.
- R5: Mode 0001 (immediate) returns kind operand with the field zero-extended. Mode 0010 (register) returns kind operand with the selected register's contents.
- R6: Mode 0011 (register indirect) returns kind address equal to the selected register's contents.
- R7: Modes 0100 (auto-increment) and 0101 (auto-decrement) return the register's old contents as the address. They also assert `res_wb_en`, with `res_wb_sel` equal to the register field and `res_wb_data` equal to the old contents plus or minus one, modulo 2^AW.
- R8: Mode 0110 (direct) returns the field zero-extended as the address.
- R9: Mode 0111 (memory-indirect) drives `mem_rd_en` for exactly one cycle, the cycle after acceptance, with `mem_rd_addr` set to the zero-extended field. The word returned in the next cycle becomes the address, and `res_valid` rises one cycle after that (three cycles after acceptance).
- R10: Mode 1000 (relative) returns the advanced PC plus the field read as a signed two's-complement value, modulo 2^AW.
- R11: Modes 1001 (indexed) and 1010 (base) return the selected register plus the zero-extended field, modulo 2^AW.
- R12: `res_kind` is encoded as 00 none, 01 operand and 10 address. `res_wb_en` is high only on results of the two auto-update modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_mode | input | 4 | Addressing mode code |
| req_reg | input | RSW | Register selector |
| req_field | input | FW | Address field |
| pc_next | input | AW | Program counter already advanced past the instruction |
| reg_rd_sel | output | RSW | Register file read selector |
| reg_rd_data | input | AW | Register file read data (combinational) |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | AW | Memory read data, valid one cycle after the request |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_value | output | AW | Effective address or operand |
| res_kind | output | 2 | Result kind: 00 none, 01 operand, 10 address |
| res_wb_en | output | 1 | Register write-back requested |
| res_wb_sel | output | RSW | Register to write back |
| res_wb_data | output | AW | Updated register value |

## Verification
The bench aims at wrap-around corners:
- auto-decrement of 0 and auto-increment of all ones, where a design that forgot the modulo width or stepped in the wrong direction would return a wrong write-back;
- a negative relative displacement, which a zero-extending design would turn into a large forward offset;
- an all-ones field in direct and base modes, which a sign-extending design would corrupt.

It holds `res_ready` low for several cycles while new requests wait, so a unit that accepts early or lets its result drift is caught. It also runs memory-indirect requests back to back, so a read pulse that is missing, lasts too long or is sampled a cycle off shows up as a wrong address or wrong latency. Unused mode codes confirm that no write-back or address leaks out.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [3:0] {
    MODE_IMPL = 4'd0,
    MODE_IMM  = 4'd1,
    MODE_REG  = 4'd2,
    MODE_RIND = 4'd3,
    MODE_AINC = 4'd4,
    MODE_ADEC = 4'd5,
    MODE_DIR  = 4'd6,
    MODE_IND  = 4'd7,
    MODE_REL  = 4'd8,
    MODE_IDX  = 4'd9,
    MODE_BASE = 4'd10
  } am_mode_e;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_OPND = 2'd1,
    KIND_ADDR = 2'd2
  } res_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WAIT = 2'd2
  } ctrl_st_e;
endpackage

// File: rtl/ea_field_ext.sv
module ea_field_ext #(
  parameter int FW = 12,
  parameter int AW = 16
) (
  input  logic [FW-1:0] field,
  output logic [AW-1:0] zext,
  output logic [AW-1:0] sext
);
  generate
    if (AW > FW) begin : g_wide
      localparam int PADW = AW - FW;
      assign zext = {{PADW{1'b0}}, field};
      assign sext = {{PADW{field[FW-1]}}, field};
    end else begin : g_narrow
      assign zext = field[AW-1:0];
      assign sext = field[AW-1:0];
    end
  endgenerate
endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [3:0]    mode,
  input  logic [AW-1:0] fld_z,
  input  logic [AW-1:0] fld_s,
  input  logic [AW-1:0] reg_val,
  input  logic [AW-1:0] pc,
  output logic [AW-1:0] value,
  output res_kind_e     kind,
  output logic          is_ind,
  output logic          wb_en,
  output logic [AW-1:0] wb_data
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  always_comb begin
    value   = '0;
    kind    = KIND_NONE;
    is_ind  = 1'b0;
    wb_en   = 1'b0;
    wb_data = '0;
    case (mode)
      MODE_IMM:  begin value = fld_z;           kind = KIND_OPND; end
      MODE_REG:  begin value = reg_val;         kind = KIND_OPND; end
      MODE_RIND: begin value = reg_val;         kind = KIND_ADDR; end
      MODE_AINC: begin
        value = reg_val; kind = KIND_ADDR; wb_en = 1'b1; wb_data = reg_val + ONE;
      end
      MODE_ADEC: begin
        value = reg_val; kind = KIND_ADDR; wb_en = 1'b1; wb_data = reg_val - ONE;
      end
      MODE_DIR:  begin value = fld_z;           kind = KIND_ADDR; end
      MODE_IND:  begin value = fld_z;           kind = KIND_ADDR; is_ind = 1'b1; end
      MODE_REL:  begin value = pc + fld_s;      kind = KIND_ADDR; end
      MODE_IDX,
      MODE_BASE: begin value = reg_val + fld_z; kind = KIND_ADDR; end
      default:   begin value = '0;              kind = KIND_NONE; end
    endcase
  end
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
#(
  parameter int AW  = 16,
  parameter int RSW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [RSW-1:0] req_reg,
  input  logic [AW-1:0]  c_value,
  input  res_kind_e      c_kind,
  input  logic           c_is_ind,
  input  logic           c_wb_en,
  input  logic [AW-1:0]  c_wb_data,
  output logic           mem_rd_en,
  output logic [AW-1:0]  mem_rd_addr,
  input  logic [AW-1:0]  mem_rd_data,
  output logic           res_valid,
  input  logic           res_ready,
  output logic [AW-1:0]  res_value,
  output logic [1:0]     res_kind,
  output logic           res_wb_en,
  output logic [RSW-1:0] res_wb_sel,
  output logic [AW-1:0]  res_wb_data
);
  ctrl_st_e      st_q;
  logic [AW-1:0] ind_addr_q;
  logic          accept;

  assign req_ready   = (st_q == ST_IDLE) && !res_valid;
  assign accept      = req_valid && req_ready;
  assign mem_rd_en   = (st_q == ST_RD);
  assign mem_rd_addr = ind_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      ind_addr_q  <= '0;
      res_valid   <= 1'b0;
      res_value   <= '0;
      res_kind    <= KIND_NONE;
      res_wb_en   <= 1'b0;
      res_wb_sel  <= '0;
      res_wb_data <= '0;
    end else begin
      if (res_valid && res_ready) res_valid <= 1'b0;
      case (st_q)
        ST_IDLE: if (accept) begin
          res_kind    <= c_kind;
          res_wb_en   <= c_wb_en;
          res_wb_sel  <= req_reg;
          res_wb_data <= c_wb_data;
          if (c_is_ind) begin
            st_q       <= ST_RD;
            ind_addr_q <= c_value;
          end else begin
            res_value <= c_value;
            res_valid <= 1'b1;
          end
        end
        ST_RD:   st_q <= ST_WAIT;
        ST_WAIT: begin
          st_q      <= ST_IDLE;
          res_value <= mem_rd_data;
          res_valid <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_value) && $stable(res_kind)
                                   && $stable(res_wb_en) && $stable(res_wb_data)));
  // R2
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && (res_valid || mem_rd_en)));
  // R3
  fast_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !c_is_ind) |=> res_valid);
  // R9
  mem_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);
  // R9
  ind_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> ##2 res_valid);
  // R9
  ind_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && c_is_ind) |=> (mem_rd_en && !res_valid));
  // R12
  wb_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_wb_en) |-> (res_kind == KIND_ADDR));
endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit
  import ea_pkg::*;
#(
  parameter int AW   = 16,
  parameter int FW   = 12,
  parameter int NREG = 8,
  localparam int RSW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [3:0]     req_mode,
  input  logic [RSW-1:0] req_reg,
  input  logic [FW-1:0]  req_field,
  input  logic [AW-1:0]  pc_next,
  output logic [RSW-1:0] reg_rd_sel,
  input  logic [AW-1:0]  reg_rd_data,
  output logic           mem_rd_en,
  output logic [AW-1:0]  mem_rd_addr,
  input  logic [AW-1:0]  mem_rd_data,
  output logic           res_valid,
  input  logic           res_ready,
  output logic [AW-1:0]  res_value,
  output logic [1:0]     res_kind,
  output logic           res_wb_en,
  output logic [RSW-1:0] res_wb_sel,
  output logic [AW-1:0]  res_wb_data
);
  logic [AW-1:0] fld_z, fld_s, c_value, c_wb_data;
  res_kind_e     c_kind;
  logic          c_is_ind, c_wb_en;

  assign reg_rd_sel = req_reg;

  ea_field_ext #(.FW(FW), .AW(AW)) u_ext (
    .field(req_field), .zext(fld_z), .sext(fld_s)
  );

  ea_calc #(.AW(AW)) u_calc (
    .mode(req_mode), .fld_z(fld_z), .fld_s(fld_s), .reg_val(reg_rd_data),
    .pc(pc_next), .value(c_value), .kind(c_kind), .is_ind(c_is_ind),
    .wb_en(c_wb_en), .wb_data(c_wb_data)
  );

  ea_ctrl #(.AW(AW), .RSW(RSW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_reg(req_reg), .c_value(c_value), .c_kind(c_kind), .c_is_ind(c_is_ind),
    .c_wb_en(c_wb_en), .c_wb_data(c_wb_data), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .res_valid(res_valid),
    .res_ready(res_ready), .res_value(res_value), .res_kind(res_kind),
    .res_wb_en(res_wb_en), .res_wb_sel(res_wb_sel), .res_wb_data(res_wb_data)
  );
endmodule

// File: tb/ea_gen_unit_tb_top.sv
module ea_gen_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, FW = 12, NREG = 8, RSW = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, res_ready = 1;
  logic [3:0] req_mode = 0;
  logic [RSW-1:0] req_reg = 0;
  logic [FW-1:0] req_field = 0;
  logic [AW-1:0] pc_next = 0;
  logic [RSW-1:0] reg_rd_sel, res_wb_sel;
  logic [AW-1:0] reg_rd_data, mem_rd_addr, res_value, res_wb_data;
  logic [AW-1:0] mem_rd_data = 0;
  logic req_ready, mem_rd_en, res_valid, res_wb_en;
  logic [1:0] res_kind;

  logic [AW-1:0] regs [NREG];
  int errors = 0, checks = 0, cyc = 0;
  bit bp = 0, run_chk = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_gen_unit #(.AW(AW), .FW(FW), .NREG(NREG)) dut_i (.*);

  assign reg_rd_data = regs[reg_rd_sel];

  function automatic int memfn(int a);
    return ((a * 257) ^ 'h5A3C) & 'hFFFF;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= memfn(int'(mem_rd_addr))[AW-1:0];
  always @(posedge clk)
    if (rst_n && res_valid && res_ready && res_wb_en) regs[res_wb_sel] <= res_wb_data;
  always @(negedge clk) begin
    cyc++;
    res_ready <= bp ? (cyc % 4 == 0) : 1'b1;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  int m_phase = 0, m_val = 0, m_kind = 0, m_wbe = 0, m_wbs = 0, m_wbd = 0, m_addr = 0;
  bit m_valid = 0;
  string m_tag = "R4";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_valid = 0;
    end else begin
      bit rdy;
      rdy = (m_phase == 0) && !m_valid;
      if (m_valid && res_ready) m_valid = 0;
      if (m_phase == 1) m_phase = 2;
      else if (m_phase == 2) begin
        m_phase = 0; m_valid = 1; m_val = memfn(m_addr);
      end else if (req_valid && rdy) begin
        int r, f, fs;
        r = int'(regs[req_reg]); f = int'(req_field);
        fs = (f >= 2048) ? f - 4096 : f;
        m_wbe = 0; m_wbs = int'(req_reg); m_wbd = 0; m_valid = 1; m_kind = 2;
        case (int'(req_mode))
          1:  begin m_val = f; m_kind = 1; m_tag = "R5"; end
          2:  begin m_val = r; m_kind = 1; m_tag = "R5"; end
          3:  begin m_val = r; m_tag = "R6"; end
          4:  begin m_val = r; m_wbe = 1; m_wbd = (r + 1) & 'hFFFF; m_tag = "R7"; end
          5:  begin m_val = r; m_wbe = 1; m_wbd = (r - 1) & 'hFFFF; m_tag = "R7"; end
          6:  begin m_val = f; m_tag = "R8"; end
          7:  begin m_valid = 0; m_phase = 1; m_addr = f; m_tag = "R9"; end
          8:  begin m_val = (int'(pc_next) + fs) & 'hFFFF; m_tag = "R10"; end
          9, 10: begin m_val = (r + f) & 'hFFFF; m_tag = "R11"; end
          default: begin m_val = 0; m_kind = 0; m_tag = "R4"; end
        endcase
      end
    end
  end

  always @(negedge clk) if (rst_n && run_chk) begin
    chk("R2", int'(req_ready), int'((m_phase == 0) && !m_valid));
    chk("R9", int'(mem_rd_en), int'(m_phase == 1));
    if (m_phase == 1) chk("R9", int'(mem_rd_addr), m_addr);
    chk("R3", int'(res_valid), int'(m_valid));
    if (m_valid && res_valid) begin
      chk(m_tag, int'(res_value), m_val);
      chk("R12", int'(res_kind), m_kind);
      chk("R12", int'(res_wb_en), m_wbe);
      if (m_wbe != 0) begin
        chk("R7", int'(res_wb_sel), m_wbs);
        chk("R7", int'(res_wb_data), m_wbd);
      end
    end
  end

  task automatic do_req(int mode, int rg, int fld, int pc);
    @(negedge clk);
    req_valid = 1; req_mode = mode[3:0]; req_reg = rg[RSW-1:0];
    req_field = fld[FW-1:0]; pc_next = pc[AW-1:0];
    while (!req_ready) @(negedge clk);
    @(posedge clk);
  endtask

  initial begin
    regs[0] = 16'h0000; regs[1] = 16'h1000; regs[2] = 16'hFFFF; regs[3] = 16'h0040;
    regs[4] = 16'h8000; regs[5] = 16'h1234; regs[6] = 16'h7FFF; regs[7] = 16'h00A5;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", int'(req_ready), 1);
    chk("R1", int'(res_valid), 0);
    chk("R1", int'(mem_rd_en), 0);
    run_chk = 1;
    do_req(0, 1, 'h123, 0);        // R4 implied
    do_req(1, 0, 'hABC, 0);        // R5 immediate
    do_req(2, 1, 0, 0);            // R5 register
    do_req(3, 3, 0, 0);            // R6
    do_req(4, 1, 0, 0);            // R7 inc
    do_req(5, 0, 0, 0);            // R7 decrement wraps 0 -> FFFF
    do_req(4, 2, 0, 0);            // R7 increment wraps FFFF -> 0
    do_req(6, 5, 'hFFF, 0);        // R8 all-ones field zero-extended
    do_req(7, 0, 'h123, 0);        // R9
    do_req(7, 0, 'hFFF, 0);        // R9 back to back
    do_req(8, 0, 24, 826);         // R10: 826 + 24 = 850
    do_req(8, 0, 'hFF0, 5);        // R10 negative displacement wraps
    do_req(9, 3, 'h100, 0);        // R11 indexed
    do_req(10, 4, 'hFFF, 0);       // R11 base
    do_req(13, 2, 'h7FF, 0);       // R4 unused code
    do_req(15, 6, 'h001, 0);       // R4 unused code
    bp = 1;                        // R2 back-pressure
    do_req(7, 0, 'h0AA, 0);
    do_req(4, 7, 0, 0);
    do_req(5, 7, 0, 0);
    do_req(8, 0, 'h800, 'h0900);
    do_req(11, 1, 'h010, 0);
    do_req(2, 0, 0, 0);
    do_req(10, 6, 1, 0);
    @(negedge clk); req_valid = 0;
    repeat (12) @(negedge clk);
    bp = 0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule